// File: doc/BRIEF.md
# Daisy-Chained TDM Audio Serializer

This block puts one stereo sample pair per frame onto a time-division-multiplexed serial line. It is built to be chained: several identical instances share one bit clock and one frame sync. Each instance reads the serial line from its upstream neighbour and drives the line to its downstream neighbour. The instance nearest the receiver has chain position 0. During the bit periods of its own 64-bit subframe an instance inserts its own left and right words. During every other bit period it retimes and forwards what arrives from upstream. The receiver at the end of the chain therefore sees one frame of `n_dev` × 64 bits, with subframe p carrying the samples of the instance at position p.

Each forwarding hop costs one bit period. To absorb this, an instance at position p starts its subframe p bit periods early in its own time base, at local bit 63·p. After p hops the subframe lands on frame bits 64·p to 64·p+63 at the receiver.

In slave mode the frame sync comes from the `fsync_in` pin. In master mode the block makes the frame sync itself, every `n_dev` × 64 bit clocks, and presents its reference clock as the bit clock. Samples arrive through a load strobe in the bit-clock domain. They are held until the next accepted frame start, so a subframe never mixes two sample periods. Frame syncs that come too early or not at all are treated as errors. On such an error the block stops driving data and waits for the next sync.

Top module: `tdm_chain_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `sdout` is 0 after the following falling edge. In slave mode (`master_en`=0), `fsync_out` and `bclk_out` stay 0.
- R2: An instance's subframe is 64 bits long: 32 bits of left, then 32 bits of right. Each half carries its 24-bit sample MSB first, followed by 8 zero bits.
- R3: Bit period 0 is the period whose rising edge samples an accepted frame sync. An instance at position p drives subframe bit j (0..63) in local bit period 63·p + j.
- R4: In a locked bit period outside the instance's own window, `sdout` carries the `sdin` value sampled at that period's rising edge. It is valid from the following falling edge, which is a one-bit-period delay.
- R5: `sdout` changes only on falling edges of `bclk`. The value present at a rising edge is the one launched at the previous falling edge.
- R6: Samples loaded with `smp_load` go into a holding stage. The subframe uses the holding contents as they stood before the accepted frame-start edge. A load at that same edge, or later in the frame, first appears in the next frame.
- R7: The frame is L = 64·n bit periods long. n is `n_dev`, with 0 treated as 1 and values above MAX_DEV treated as MAX_DEV. The next sync is expected exactly L periods after the previous accepted one.
- R8: A sync that arrives while locked but before bit period L is an early sync. That period and every following period output 0 until the next sync, which is accepted.
- R9: If no sync arrives at bit period L, the sync is missing. That period and every following period output 0 until the next sync, which is accepted.
- R10: In master mode, `fsync_in` is ignored. The internal sync is high for one bit period every L periods, starting with the first period after reset. `fsync_out` shows it during that same period. `bclk_out` follows `bclk`.
- R11: After reset the block outputs 0 until the first sync. That first sync is always accepted as bit period 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; the reference clock when in master mode |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1 = generate frame sync and bit clock output, 0 = follow `fsync_in` |
| n_dev | input | 4 | Number of chained instances (clamped to 1..MAX_DEV) |
| chain_pos | input | 3 | Position of this instance, 0 = nearest the receiver |
| fsync_in | input | 1 | Frame sync in slave mode, one bit period wide |
| smp_load | input | 1 | Load strobe for the sample pair |
| smp_left | input | 24 | Left sample |
| smp_right | input | 24 | Right sample |
| sdin | input | 1 | Serial data from the upstream instance |
| sdout | output | 1 | Serial data to the downstream instance or receiver |
| bclk_out | output | 1 | Bit clock output, active in master mode only |
| fsync_out | output | 1 | Generated frame sync, active in master mode only |

## Verification
The assertions check, on every cycle, the local rules of the block:
- `sdout` always matches the bit prepared at the preceding rising edge.
- Unlocked periods produce zeros.
- Forwarded bits equal the sampled `sdin`.
- An early or missing sync always drops lock.
- The frozen subframe word changes only at a frame start.
- The generated sync is a single-period pulse.

Whether the right bit sits at the right frame position can only be shown by the bench's scenarios, which compare whole frames against an independent model. Those scenarios cover the 63·p window offset at several positions, the frame in which a new sample first appears, the clamping of `n_dev`, and recovery after early and missing syncs.

// File: rtl/tdm_chain_pkg.sv
// Shared types and helpers for the daisy-chained TDM serializer.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package tdm_chain_pkg;

    // Lock state of the frame tracker.
    typedef enum logic {
        TRK_HUNT = 1'b0,
        TRK_RUN  = 1'b1
    } trk_state_e;

    // Limit a requested chain length to the supported range 1..max_dev.
    function automatic int unsigned clamp_dev(input int unsigned req, input int unsigned max_dev);
        if (req == 0) begin
            return 1;
        end else if (req > max_dev) begin
            return max_dev;
        end
        return req;
    endfunction

endpackage

// File: rtl/tdm_sync_gen.sv
// Master-mode frame sync generator.
// Counts bit periods modulo the frame length. The sync is high during the
// period in which the count is zero, so the first period after reset carries
// a sync. Assumes frame_len >= 2 and stays constant while master_en is high.
module tdm_sync_gen #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [CNT_W-1:0] frame_len,
    output logic             fs_gen
);

    logic [CNT_W-1:0] gen_q;

    // Advance the period counter, wrapping at the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else if (!master_en) begin
            gen_q <= '0;
        end else if (gen_q >= frame_len - 1'b1) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_q + 1'b1;
        end
    end

    // Sync is visible for exactly the period in which the count is zero.
    assign fs_gen = master_en && (gen_q == '0);

    // R10: the generated sync never lasts two periods
    a_r10_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        fs_gen |=> !fs_gen);

endmodule

// File: rtl/tdm_frame_tracker.sv
// Frame tracker: acquires the frame sync and counts bit periods.
// Checks that each following sync lands exactly one frame length later.
// Produces the bit index of the current period, a frame-start flag for the
// period that carries an accepted sync, and an active flag. Active is low
// in every period whose output must be zero: hunting, or the period of an
// early or missing sync.
module tdm_frame_tracker
    import tdm_chain_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    input  logic [CNT_W-1:0] frame_len,
    output logic [CNT_W-1:0] cur_idx,
    output logic             frame_start,
    output logic             active
);

    trk_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;     // index expected for the current period
    logic             at_end;
    logic             sync_err;

    // Decide whether this period starts a frame, breaks lock, or continues.
    always_comb begin
        at_end = (cnt_q >= frame_len);
        if (state_q == TRK_HUNT) begin
            frame_start = fs;
            sync_err    = 1'b0;
        end else begin
            frame_start = fs && at_end;
            sync_err    = fs ^ at_end;
        end
        cur_idx = frame_start ? '0 : cnt_q;
        active  = frame_start || ((state_q == TRK_RUN) && !sync_err);
    end

    // Update lock state and the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_HUNT;
            cnt_q   <= '0;
        end else if (sync_err) begin
            state_q <= TRK_HUNT;
            cnt_q   <= '0;
        end else if (frame_start) begin
            state_q <= TRK_RUN;
            cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else if (state_q == TRK_RUN) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R8: a sync arriving before the frame end drops lock
    a_r8_early_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_RUN && fs && cnt_q < frame_len) |=> (state_q == TRK_HUNT));

    // R9: no sync at the frame end drops lock
    a_r9_missing_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_RUN && !fs && cnt_q >= frame_len) |=> (state_q == TRK_HUNT));

    // R7: an on-time sync restarts the count at one for the next period
    a_r7_on_time_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_RUN && fs && cnt_q == frame_len) |=> (state_q == TRK_RUN && cnt_q == 1));

    // R11: hunting without a sync never enables output
    a_r11_hunt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_HUNT && !fs) |-> !active);

endmodule

// File: rtl/tdm_sample_store.sv
// Two-stage sample storage.
// A holding stage captures each load strobe. A frame stage takes the holding
// contents at an accepted frame start and keeps them for the whole frame.
// The word offered to the slot mux is the frame stage, or, in the
// frame-start period itself, the holding contents about to be frozen.
// Assumes SLOT_W > SAMPLE_W.
module tdm_sample_store #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int SUB_W    = 2 * SLOT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    input  logic                frame_start,
    output logic [SUB_W-1:0]    word
);

    localparam int PAD_W = SLOT_W - SAMPLE_W;

    logic [SAMPLE_W-1:0] hold_l_q;
    logic [SAMPLE_W-1:0] hold_r_q;
    logic [SUB_W-1:0]    fresh;
    logic [SUB_W-1:0]    frame_q;

    // Capture the most recent sample pair on each load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_q <= '0;
            hold_r_q <= '0;
        end else if (load) begin
            hold_l_q <= left;
            hold_r_q <= right;
        end
    end

    // Arrange the held pair as a left-justified left/right subframe.
    assign fresh = {hold_l_q, {PAD_W{1'b0}}, hold_r_q, {PAD_W{1'b0}}};

    // Freeze the subframe for the frame that starts now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (frame_start) begin
            frame_q <= fresh;
        end
    end

    // Offer the word that belongs to the current frame.
    assign word = frame_start ? fresh : frame_q;

    // R6: the frozen subframe only changes at a frame start
    a_r6_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_q));

endmodule

// File: rtl/tdm_slot_mux.sv
// Per-bit source selection and output retiming.
// In its own window (local periods 63*p .. 63*p+63) the mux takes the
// subframe bit. Elsewhere it takes the upstream bit. When inactive it takes
// zero. The choice is registered on the rising edge and launched on the
// falling edge, so a receiver can sample on the next rising edge.
// Assumes SUB_W is a power of two.
module tdm_slot_mux #(
    parameter int SUB_W = 64,
    parameter int CNT_W = 10,
    parameter int POS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] cur_idx,
    input  logic [POS_W-1:0] chain_pos,
    input  logic [SUB_W-1:0] word,
    input  logic             sdin,
    output logic             sdout
);

    localparam int OFF_W  = $clog2(SUB_W);
    localparam int BASE_W = (CNT_W > POS_W + OFF_W) ? CNT_W : (POS_W + OFF_W);
    localparam int WIDE_W = BASE_W + 1;

    logic [WIDE_W-1:0] win_lo;
    logic [WIDE_W-1:0] idx_w;
    logic [WIDE_W-1:0] off_w;
    logic              in_win;
    logic [OFF_W-1:0]  sel;
    logic              nxt_bit;
    logic              dpos_q;
    logic              sdout_q;

    // Locate the own window and pick the bit for the current period.
    always_comb begin
        win_lo  = WIDE_W'(chain_pos) * WIDE_W'(SUB_W - 1);
        idx_w   = WIDE_W'(cur_idx);
        off_w   = idx_w - win_lo;
        in_win  = (idx_w >= win_lo) && (off_w < WIDE_W'(SUB_W));
        sel     = OFF_W'(SUB_W - 1) - off_w[OFF_W-1:0];
        if (!active) begin
            nxt_bit = 1'b0;
        end else if (in_win) begin
            nxt_bit = word[sel];
        end else begin
            nxt_bit = sdin;
        end
    end

    // Register the chosen bit on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dpos_q <= 1'b0;
        end else begin
            dpos_q <= nxt_bit;
        end
    end

    // Launch the registered bit on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sdout_q <= 1'b0;
        end else begin
            sdout_q <= dpos_q;
        end
    end

    assign sdout = sdout_q;

    // R11: inactive periods produce a zero bit
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !dpos_q);

    // R4: outside the own window the upstream bit is forwarded
    a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !in_win) |=> (dpos_q == $past(sdin)));

    // R5: at each rising edge the line holds the bit launched on the prior fall
    a_r5_fall_launch: assert property (@(posedge clk) disable iff (!rst_n)
        sdout_q == dpos_q);

endmodule

// File: rtl/tdm_chain_serializer.sv
// Top of the daisy-chained TDM serializer.
// Chooses the frame sync source (pin or internal generator), derives the
// frame length from the chain length, and connects the tracker, the sample
// store and the slot mux. The whole block runs on the bit clock. In master
// mode that clock is the reference clock, passed straight to bclk_out.
module tdm_chain_serializer
    import tdm_chain_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32,
    parameter int MAX_DEV  = 8,
    parameter int DEV_W    = $clog2(MAX_DEV + 1),
    parameter int POS_W    = $clog2(MAX_DEV)
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic [DEV_W-1:0]    n_dev,
    input  logic [POS_W-1:0]    chain_pos,
    input  logic                fsync_in,
    input  logic                smp_load,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                sdin,
    output logic                sdout,
    output logic                bclk_out,
    output logic                fsync_out
);

    localparam int SUB_W = 2 * SLOT_W;
    localparam int CNT_W = $clog2(MAX_DEV * SUB_W + 1);

    logic [CNT_W-1:0] frame_len;
    logic             fs_gen;
    logic             fs_eff;
    logic [CNT_W-1:0] cur_idx;
    logic             frame_start;
    logic             active;
    logic [SUB_W-1:0] word;

    // Frame length from the clamped chain length.
    assign frame_len = CNT_W'(clamp_dev(32'(n_dev), MAX_DEV) * SUB_W);

    // Frame sync source and the clock and sync outputs for master mode.
    assign fs_eff    = master_en ? fs_gen : fsync_in;
    assign fsync_out = fs_gen;
    assign bclk_out  = bclk & master_en;

    tdm_sync_gen #(
        .CNT_W (CNT_W)
    ) u_sync_gen (
        .clk       (bclk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .frame_len (frame_len),
        .fs_gen    (fs_gen)
    );

    tdm_frame_tracker #(
        .CNT_W (CNT_W)
    ) u_tracker (
        .clk         (bclk),
        .rst_n       (rst_n),
        .fs          (fs_eff),
        .frame_len   (frame_len),
        .cur_idx     (cur_idx),
        .frame_start (frame_start),
        .active      (active)
    );

    tdm_sample_store #(
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W),
        .SUB_W    (SUB_W)
    ) u_store (
        .clk         (bclk),
        .rst_n       (rst_n),
        .load        (smp_load),
        .left        (smp_left),
        .right       (smp_right),
        .frame_start (frame_start),
        .word        (word)
    );

    tdm_slot_mux #(
        .SUB_W (SUB_W),
        .CNT_W (CNT_W),
        .POS_W (POS_W)
    ) u_mux (
        .clk       (bclk),
        .rst_n     (rst_n),
        .active    (active),
        .cur_idx   (cur_idx),
        .chain_pos (chain_pos),
        .word      (word),
        .sdin      (sdin),
        .sdout     (sdout)
    );

    // R10: in slave mode no sync is generated
    a_r10_slave_no_sync: assert property (@(posedge bclk) disable iff (!rst_n)
        !master_en |-> !fsync_out);

endmodule

// File: tb/test_tdm_chain_serializer.sv
// Scoreboard bench: the driver task models each bit period from the
// requirements and queues the expected serial bit; the monitor pops it after
// the falling edge and compares it with sdout.
module test_tdm_chain_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 24;
    localparam int MAXD       = 8;

    logic          bclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_en = 1'b0;
    logic [3:0]    n_dev = 4'd4;
    logic [2:0]    chain_pos = 3'd0;
    logic          fsync_in = 1'b0;
    logic          smp_load = 1'b0;
    logic [SW-1:0] smp_left = '0;
    logic [SW-1:0] smp_right = '0;
    logic          sdin = 1'b0;
    logic          sdout;
    logic          bclk_out;
    logic          fsync_out;

    int checks = 0;
    int errors = 0;

    // model state
    bit            m_lock;
    int            m_pos;
    int            m_gen;
    int            hunt_req;
    int            scen;
    logic [SW-1:0] pend_l, pend_r, frm_l, frm_r;
    logic          last_exp;
    logic [15:0]   lfsr = 16'hACE1;
    logic          exp_q[$];
    int            req_q[$];

    tdm_chain_serializer i_tdm_chain_serializer (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .n_dev     (n_dev),
        .chain_pos (chain_pos),
        .fsync_in  (fsync_in),
        .smp_load  (smp_load),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .sdin      (sdin),
        .sdout     (sdout),
        .bclk_out  (bclk_out),
        .fsync_out (fsync_out)
    );

    always #(CLK_PERIOD / 2) bclk = ~bclk;

    task automatic check(input bit ok, input int req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s at %0t: actual=%0h expected=%0h", req, what, $time, act, expv);
        end
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic int frame_bits();
        int n = int'(n_dev);
        if (n == 0) n = 1;        // R7 clamp low
        if (n > MAXD) n = MAXD;   // R7 clamp high
        return n * 64;
    endfunction

    // Monitor: compare sdout with the queued expectation after each falling edge.
    initial begin
        forever begin
            @(negedge bclk);
            #2;
            if (exp_q.size() > 0) begin
                logic e;
                int   r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(sdout === e, r, "serial bit", 64'(sdout), 64'(e));
            end
        end
    end

    // Driver: one bit period. Called just after a falling edge.
    task automatic step(input logic fs, input logic din, input logic ld,
                        input logic [SW-1:0] l, input logic [SW-1:0] r);
        int   len;
        bit   eff;
        bit   err;
        logic e;
        int   rq;
        logic [63:0] word;
        int   lo;
        fsync_in  = fs;
        sdin      = din;
        smp_load  = ld;
        smp_left  = l;
        smp_right = r;
        len = frame_bits();
        // R10: generated sync visible during the period it marks
        check(fsync_out === (master_en && m_gen == 0), 10, "fsync_out",
              64'(fsync_out), 64'(master_en && m_gen == 0));
        eff = master_en ? (m_gen == 0) : fs;
        err = 1'b0;
        if (eff && (!m_lock || m_pos == len - 1)) begin
            m_lock = 1'b1;
            m_pos  = 0;
            frm_l  = pend_l;   // R6: previous holding contents
            frm_r  = pend_r;
        end else if (m_lock && (eff || m_pos == len - 1)) begin
            m_lock   = 1'b0;
            err      = 1'b1;
            hunt_req = eff ? 8 : 9;   // R8 early, R9 missing
        end else if (m_lock) begin
            m_pos++;
        end
        if (ld) begin
            pend_l = l;
            pend_r = r;
        end
        m_gen = master_en ? ((m_gen == len - 1) ? 0 : m_gen + 1) : 0;
        lo = int'(chain_pos) * 63;
        word = {frm_l, 8'h00, frm_r, 8'h00};
        if (!m_lock) begin
            e  = 1'b0;
            rq = err ? hunt_req : hunt_req;
        end else if (m_pos >= lo && m_pos < lo + 64) begin
            e  = word[63 - (m_pos - lo)];   // R2 / R3
            rq = (scen != 0) ? scen : 2;
        end else begin
            e  = din;                        // R4
            rq = 4;
        end
        @(posedge bclk);
        #1;
        // R5: line still carries the previous bit just after the rising edge
        check(sdout === last_exp, 5, "sdout before fall", 64'(sdout), 64'(last_exp));
        // R10: bit clock output follows bclk only in master mode
        check(bclk_out === master_en, 10, "bclk_out", 64'(bclk_out), 64'(master_en));
        exp_q.push_back(e);
        req_q.push_back(rq);
        last_exp = e;
        @(negedge bclk);
        #1;
    endtask

    task automatic frame(input int len, input int ld_at, input logic [SW-1:0] l,
                         input logic [SW-1:0] r, input int fs_at);
        for (int i = 0; i < len; i++) begin
            step(i == fs_at, next_bit(), i == ld_at, l, r);
        end
    endtask

    task automatic do_reset(input logic mst, input logic [3:0] n, input logic [2:0] p);
        rst_n     = 1'b0;
        master_en = mst;
        n_dev     = n;
        chain_pos = p;
        fsync_in  = 1'b0;
        sdin      = 1'b1;
        smp_load  = 1'b0;
        repeat (3) begin
            @(negedge bclk);
            #1;
        end
        // R1: line is low in reset; slave outputs quiet
        check(sdout === 1'b0, 1, "sdout in reset", 64'(sdout), 64'd0);
        if (!mst) begin
            check(fsync_out === 1'b0, 1, "fsync_out slave reset", 64'(fsync_out), 64'd0);
            check(bclk_out === 1'b0, 1, "bclk_out slave reset", 64'(bclk_out), 64'd0);
        end
        m_lock   = 1'b0;
        m_pos    = 0;
        m_gen    = 0;
        hunt_req = 11;
        pend_l   = '0;
        pend_r   = '0;
        frm_l    = '0;
        frm_r    = '0;
        last_exp = 1'b0;
        rst_n    = 1'b1;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1, R11: reset, then zeros while hunting; load before first sync
        do_reset(1'b0, 4'd4, 3'd0);
        scen = 11;
        frame(10, 3, 24'hA5C3F1, 24'h1E2D3C, -1);
        // R2: position 0 subframe layout over several frames
        scen = 2;
        frame(256, -1, '0, '0, 0);
        frame(256, 40, 24'h800001, 24'h7FFFFE, 0);
        frame(256, -1, '0, '0, 0);

        // R3: window offset at positions 2 and 3
        scen = 3;
        do_reset(1'b0, 4'd4, 3'd2);
        frame(256, 5, 24'h123456, 24'hFEDCBA, 0);
        frame(256, -1, '0, '0, 0);
        do_reset(1'b0, 4'd4, 3'd3);
        frame(256, 7, 24'hF0F0F0, 24'h0F0F0F, 0);
        frame(256, -1, '0, '0, 0);

        // R6: load on the frame-start edge and mid-frame take effect next frame
        scen = 6;
        do_reset(1'b0, 4'd4, 3'd1);
        frame(256, 0, 24'hC0FFEE, 24'hBADA55, 0);
        frame(256, -1, '0, '0, 0);
        frame(256, 100, 24'h13579B, 24'h2468AC, 0);
        frame(256, -1, '0, '0, 0);

        // R8: early sync then recovery
        scen = 8;
        do_reset(1'b0, 4'd2, 3'd0);
        frame(128, 3, 24'h55AA55, 24'hAA55AA, 0);
        frame(128, -1, '0, '0, 0);
        frame(60, -1, '0, '0, 0);
        frame(128, -1, '0, '0, 0);
        frame(128, -1, '0, '0, 0);
        frame(128, -1, '0, '0, 0);

        // R9: missing sync then recovery
        scen = 9;
        frame(150, -1, '0, '0, -1);
        frame(128, -1, '0, '0, 0);
        frame(128, -1, '0, '0, 0);

        // R7: chain length clamping (0 -> 1, 15 -> MAX)
        scen = 7;
        do_reset(1'b0, 4'd0, 3'd0);
        frame(64, 2, 24'h00FF00, 24'hFF00FF, 0);
        frame(64, -1, '0, '0, 0);
        frame(64, -1, '0, '0, 0);
        do_reset(1'b0, 4'd15, 3'd7);
        frame(512, 2, 24'h3C3C3C, 24'hC3C3C3, 0);
        frame(512, -1, '0, '0, 0);

        // R10: master mode ignores fsync_in and generates its own sync
        scen = 10;
        do_reset(1'b1, 4'd2, 3'd1);
        frame(128, 3, 24'h6B6B6B, 24'h949494, 50);
        frame(128, -1, '0, '0, 17);
        frame(128, -1, '0, '0, 0);

        @(negedge bclk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule